// File: doc/BRIEF.md
# Auto-Increment Byte Register Front End

This block is the byte-level register file of a power-management companion device. It sits behind a serial slave that has already done the bit-level work and hands over three strobes: a start of a write transfer, a written byte, and a read request. The first byte after a start is a register address. It loads an 8-bit pointer. Each later written byte lands at the pointer, and each read returns the byte at the pointer. The pointer steps by one after every data byte in either direction, so a host can stream through neighbouring registers in a single transfer.

The bank holds supply-voltage, regulator, sleep, oscillator, detect, pull-resistor and card-interface control bytes. Every register stores only its writable bits and comes out of reset at its own value. The three core-voltage code fields saturate instead of wrapping. A fixed revision byte identifies the device. Writing a 1 to bit 0 of a command register puts every register back to its reset value.

Top module: `pmic_reg_front`

## Requirements
- R1: After `wr_start`, the next written byte loads the pointer and is stored in no register.
- R2: Each later written byte goes to the register at the pointer, and each read returns the byte at the pointer. The pointer then increments by one, and it wraps from 0xFF to 0x00.
- R3: Address 0x01 always reads 0x22, and writes to it have no effect.
- R4: A write to 0x04 or 0x05 stores min(data & 0x1F, 0x12).
- R5: A write to 0x02 stores (data & 0x0E) | min(data & 0x1F, 0x12).
- R6: A write to 0x14 with bit 0 set returns every register to its reset value. A write to 0x14 with bit 0 clear changes nothing. 0x14 always reads 0x00.
- R7: Address 0x15 keeps only bits 2:0 of a write, and a read of it always has bit 7 set.
- R8: Per-register write masks apply:
  - 0x3F at 0x07 and 0x3A
  - 0x7F at 0x0B and 0x16
  - 0x03 at 0x06 and at 0x0C to 0x11
  - 0x07 at 0x08 and 0x09
  - 0x1F at 0x33 and 0x35
  - 0x7F at 0x36 and 0x0F at 0x38
  - all 8 bits at 0x03, 0x0A, 0x12, 0x13, 0x32, 0x34 and 0x37
- R9: The reset values are:
  - 0x0C, 0x05, 0x02, 0x0C and 0x03 at 0x02 to 0x06
  - 0x33, 0x03 and 0x00 at 0x07 to 0x09
  - 0x95, 0x7E, 0x00, 0x00 and 0x03 at 0x0A to 0x0E
  - 0x01 at 0x15 and 0x09 at 0x16
  - 0x03 and 0xC0 at 0x36 and 0x37
  - 0x05 at 0x3A
  - 0x00 at every other mapped register
- R10: Unmapped addresses (0x00, 0x39, 0x17 to 0x31, and 0x3B and above) read 0x00 and ignore writes. The pointer still advances on them.
- R11: When strobes coincide, `wr_start` takes precedence over `wr_valid`, which takes precedence over `rd_strobe`, and the lower-priority strobes are dropped. `rd_data` changes only at the clock edge that accepts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start of a write transfer; the next byte is an address |
| wr_valid | input | 1 | A written byte is present on `wr_data` |
| wr_data | input | 8 | Written byte |
| rd_strobe | input | 1 | Read request for the byte at the pointer |
| rd_data | output | 8 | Registered read data, valid from the edge that accepts the read |

## Verification
The bench targets the saturation points of the core-voltage fields and the mixed mask-and-clamp rule at 0x02. A design that wrapped, or that clamped before masking, stores a value above 0x12 or loses bits 3:1. The bench streams through 0xFF so that the following reads must come from 0x00 and 0x01. A pointer that saturated, or that did not advance, returns the wrong bytes there.

For the soft reset, the bench writes both polarities of bit 0. A design that decoded the whole byte, or that ignored the trigger, leaves modified values in place. The bench also sends coincident strobes, and checks that the address byte and unmapped addresses leave no register changed. A design with the wrong priority, or one that stored the address byte, corrupts a register the bench later reads.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAP_SPAN = 64;
  localparam int IDX_W    = $clog2(MAP_SPAN);

  localparam logic [BYTE_W-1:0] A_REV     = 8'h01;
  localparam logic [BYTE_W-1:0] A_CORE0   = 8'h02;
  localparam logic [BYTE_W-1:0] A_CORE2   = 8'h04;
  localparam logic [BYTE_W-1:0] A_CORE3   = 8'h05;
  localparam logic [BYTE_W-1:0] A_SOFTRST = 8'h14;
  localparam logic [BYTE_W-1:0] A_OSC     = 8'h15;

  localparam logic [BYTE_W-1:0] REV_CODE  = 8'h22;
  localparam logic [BYTE_W-1:0] CLK_GOOD  = 8'h80;
  localparam logic [BYTE_W-1:0] CORE_CEIL = 8'h12;
  localparam logic [BYTE_W-1:0] CODE_MASK = 8'h1F;
  localparam logic [BYTE_W-1:0] KEEP_MASK = 8'h0E;

  typedef struct packed {
    logic              mapped;
    logic [BYTE_W-1:0] wmask;
    logic [BYTE_W-1:0] init;
  } slot_cfg_t;

  function automatic slot_cfg_t mk(input logic [BYTE_W-1:0] m, input logic [BYTE_W-1:0] i);
    slot_cfg_t c;
    c.mapped = 1'b1;
    c.wmask  = m;
    c.init   = i;
    return c;
  endfunction

  function automatic slot_cfg_t cfg_of(input logic [BYTE_W-1:0] a);
    slot_cfg_t c;
    c = '0;
    case (a)
      8'h02: c = mk(8'hFF, 8'h0C);
      8'h03: c = mk(8'hFF, 8'h05);
      8'h04: c = mk(8'hFF, 8'h02);
      8'h05: c = mk(8'hFF, 8'h0C);
      8'h06: c = mk(8'h03, 8'h03);
      8'h07: c = mk(8'h3F, 8'h33);
      8'h08: c = mk(8'h07, 8'h03);
      8'h09: c = mk(8'h07, 8'h00);
      8'h0A: c = mk(8'hFF, 8'h95);
      8'h0B: c = mk(8'h7F, 8'h7E);
      8'h0C, 8'h0D, 8'h0F, 8'h10, 8'h11: c = mk(8'h03, 8'h00);
      8'h0E: c = mk(8'h03, 8'h03);
      8'h12, 8'h13: c = mk(8'hFF, 8'h00);
      8'h15: c = mk(8'h07, 8'h01);
      8'h16: c = mk(8'h7F, 8'h09);
      8'h32, 8'h34: c = mk(8'hFF, 8'h00);
      8'h33, 8'h35: c = mk(8'h1F, 8'h00);
      8'h36: c = mk(8'h7F, 8'h03);
      8'h37: c = mk(8'hFF, 8'hC0);
      8'h38: c = mk(8'h0F, 8'h00);
      8'h3A: c = mk(8'h3F, 8'h05);
      default: c = '0;
    endcase
    return c;
  endfunction

  // Value actually stored for a write of d at address a.
  function automatic logic [BYTE_W-1:0] shape(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] code;
    logic [BYTE_W-1:0] sat;
    code = d & CODE_MASK;
    sat  = (code > CORE_CEIL) ? CORE_CEIL : code;
    case (a)
      A_CORE0:          return (d & KEEP_MASK) | sat;
      A_CORE2, A_CORE3: return sat;
      default:          return d & cfg_of(a).wmask;
    endcase
  endfunction
endpackage

// File: rtl/prf_ptr.sv
module prf_ptr
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_strobe,
  output logic [BYTE_W-1:0] ptr,
  output logic              we,
  output logic              rd_fire
);
  logic addr_phase;

  assign we      = !wr_start && wr_valid && !addr_phase;
  assign rd_fire = !wr_start && !wr_valid && rd_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      addr_phase <= 1'b0;
    end else if (wr_start) begin
      addr_phase <= 1'b1;
    end else if (wr_valid) begin
      if (addr_phase) begin
        ptr        <= wr_data;
        addr_phase <= 1'b0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (rd_strobe) begin
      ptr <= ptr + 1'b1;
    end
  end

  // R1: the byte after a start becomes the pointer
  p_addr_load_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_start && wr_valid && addr_phase) |=> (ptr == $past(wr_data)) && !addr_phase);

  // R2: every accepted data byte steps the pointer with wrap
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (we || rd_fire) |=> ptr == $past(ptr) + 8'd1);

  // R11: at most one action per cycle
  p_one_action_r11: assert property (@(posedge clk) disable iff (rst)
    !(we && rd_fire));
endmodule

// File: rtl/prf_bank.sv
module prf_bank
  import prf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [BYTE_W-1:0]              waddr,
  input  logic [BYTE_W-1:0]              wdata,
  output logic [MAP_SPAN-1:0][BYTE_W-1:0] regs
);
  logic              soft_rst;
  logic [BYTE_W-1:0] wval;

  assign soft_rst = we && (waddr == A_SOFTRST) && wdata[0];
  assign wval     = shape(waddr, wdata);

  for (genvar g = 0; g < MAP_SPAN; g++) begin : g_slot
    localparam slot_cfg_t C = cfg_of(8'(g));
    if (C.mapped) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst || soft_rst)              q <= C.init;
        else if (we && waddr == 8'(g))    q <= wval;
      end
      assign regs[g] = q;
    end else begin : g_hole
      assign regs[g] = '0;
    end
  end

  // R4: saturated core-voltage codes never exceed the ceiling
  p_core_ceiling_r4: assert property (@(posedge clk) disable iff (rst)
    (regs[A_CORE2[IDX_W-1:0]] <= CORE_CEIL) && (regs[A_CORE3[IDX_W-1:0]] <= CORE_CEIL));

  // R6: soft reset trigger restores reset values
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == A_SOFTRST && wdata[0]) |=> (regs[2] == 8'h0C) && (regs[58] == 8'h05));

  // R8: masked registers hold no bit outside their mask
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    ((regs[7] & 8'hC0) == 8'h00) && ((regs[11] & 8'h80) == 8'h00));
endmodule

// File: rtl/prf_rdmux.sv
module prf_rdmux
  import prf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_fire,
  input  logic [BYTE_W-1:0]              ptr,
  input  logic [MAP_SPAN-1:0][BYTE_W-1:0] regs,
  output logic [BYTE_W-1:0]              rd_data
);
  logic [BYTE_W-1:0] sel;

  always_comb begin
    if (ptr == A_REV)                 sel = REV_CODE;
    else if (ptr == A_OSC)            sel = regs[A_OSC[IDX_W-1:0]] | CLK_GOOD;
    else if (ptr < BYTE_W'(MAP_SPAN)) sel = regs[ptr[IDX_W-1:0]];
    else                              sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_fire) rd_data <= sel;
  end

  // R3: revision byte
  p_rev_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && ptr == A_REV) |=> rd_data == REV_CODE);

  // R7: clock-good flag
  p_clk_good_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && ptr == A_OSC) |=> rd_data[7]);

  // R11: read data holds without an accepted read
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rd_data));
endmodule

// File: rtl/pmic_reg_front.sv
module pmic_reg_front
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_strobe,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0]               ptr;
  logic                            we;
  logic                            rd_fire;
  logic [MAP_SPAN-1:0][BYTE_W-1:0] regs;

  prf_ptr i_ptr (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .ptr(ptr), .we(we), .rd_fire(rd_fire)
  );

  prf_bank i_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(ptr), .wdata(wr_data), .regs(regs)
  );

  prf_rdmux i_rdmux (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .ptr(ptr), .regs(regs), .rd_data(rd_data)
  );
endmodule

// File: tb/test_pmic_reg_front.sv
module test_pmic_reg_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_start = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pmic_reg_front i_pmic_reg_front (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic start_w();
    @(negedge clk); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    b = rd_data;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    start_w(); send(a); send(d);
  endtask

  task automatic rd_at(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    start_w(); send(a); recv(v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    rd_at("R9 core0", 8'h02, 8'h0C);
    rd_at("R9 core1", 8'h03, 8'h05);
    rd_at("R9 core2", 8'h04, 8'h02);
    rd_at("R9 core3", 8'h05, 8'h0C);
    rd_at("R9 core4", 8'h06, 8'h03);
    rd_at("R9 ldo0", 8'h0A, 8'h95);
    rd_at("R9 ldo1", 8'h0B, 8'h7E);
    rd_at("R9 debounce", 8'h3A, 8'h05);
    rd_at("R9 card1", 8'h37, 8'hC0);
  endtask

  task automatic t_addr_byte();
    wr1(8'h03, 8'hA5);
    rd_at("R1 data stored", 8'h03, 8'hA5);
    rd_at("R1 neighbour", 8'h02, 8'h0C);
  endtask

  task automatic t_burst();
    logic [7:0] v;
    start_w(); send(8'h12); send(8'h11); send(8'h22);
    start_w(); send(8'h12); recv(v); chk("R2 burst 0x12", v, 8'h11);
    recv(v); chk("R2 burst 0x13", v, 8'h22);
    recv(v); chk("R2 burst 0x14", v, 8'h00);
    start_w(); send(8'hFF); send(8'h77);
    recv(v); chk("R2 wrap to 0x00", v, 8'h00);
    recv(v); chk("R2 wrap to 0x01", v, 8'h22);
  endtask

  task automatic t_rev();
    wr1(8'h01, 8'h55);
    rd_at("R3 revision", 8'h01, 8'h22);
  endtask

  task automatic t_clamp();
    wr1(8'h04, 8'hFF); rd_at("R4 clamp ff", 8'h04, 8'h12);
    wr1(8'h05, 8'h11); rd_at("R4 pass 11", 8'h05, 8'h11);
    wr1(8'h04, 8'h33); rd_at("R4 clamp 33", 8'h04, 8'h12);
    wr1(8'h02, 8'h1F); rd_at("R5 1f", 8'h02, 8'h1E);
    wr1(8'h02, 8'h07); rd_at("R5 07", 8'h02, 8'h07);
    wr1(8'h02, 8'h93); rd_at("R5 93", 8'h02, 8'h12);
  endtask

  task automatic t_masks();
    wr1(8'h15, 8'hFF); rd_at("R7 osc", 8'h15, 8'h87);
    wr1(8'h07, 8'hFF); rd_at("R8 0x07", 8'h07, 8'h3F);
    wr1(8'h0B, 8'hFF); rd_at("R8 0x0B", 8'h0B, 8'h7F);
    wr1(8'h0C, 8'hFF); rd_at("R8 0x0C", 8'h0C, 8'h03);
    wr1(8'h11, 8'hFF); rd_at("R8 0x11", 8'h11, 8'h03);
    wr1(8'h33, 8'hFF); rd_at("R8 0x33", 8'h33, 8'h1F);
    wr1(8'h3A, 8'hFF); rd_at("R8 0x3A", 8'h3A, 8'h3F);
  endtask

  task automatic t_unmapped();
    wr1(8'h20, 8'hAB); rd_at("R10 write ignored", 8'h20, 8'h00);
    rd_at("R10 0x39", 8'h39, 8'h00);
    rd_at("R10 0xC0", 8'hC0, 8'h00);
  endtask

  task automatic t_soft_reset();
    wr1(8'h14, 8'hFE);
    rd_at("R6 no trigger", 8'h03, 8'hA5);
    rd_at("R6 reads zero", 8'h14, 8'h00);
    wr1(8'h14, 8'h01);
    rd_at("R6 core1 restored", 8'h03, 8'h05);
    rd_at("R6 dcdc restored", 8'h07, 8'h33);
    rd_at("R6 osc restored", 8'h15, 8'h81);
    rd_at("R6 debounce restored", 8'h3A, 8'h05);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    @(negedge clk); wr_start = 1'b1; wr_valid = 1'b1; wr_data = 8'h5A;
    @(negedge clk); wr_start = 1'b0; wr_valid = 1'b0;
    send(8'h08); send(8'h06);
    rd_at("R11 start over write", 8'h08, 8'h06);
    start_w(); send(8'h0A);
    @(negedge clk); wr_valid = 1'b1; rd_strobe = 1'b1; wr_data = 8'h44;
    @(negedge clk); wr_valid = 1'b0; rd_strobe = 1'b0;
    rd_at("R11 write over read", 8'h0A, 8'h44);
    start_w(); send(8'h0B); recv(v);
    repeat (3) @(negedge clk);
    chk("R11 rd_data holds", rd_data, 8'h7E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset rd_data", rd_data, 8'h00);
    rst = 1'b0;
    t_reset();
    t_addr_byte();
    t_burst();
    t_rev();
    t_clamp();
    t_masks();
    t_unmapped();
    t_soft_reset();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule